// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles and returns the full signed product of `2*WIDTH` bits. It recodes the multiplier two bits at a time. The low bit of the multiplier register is paired with a guard bit that holds the bit most recently shifted out. That pair selects one of three actions: add the multiplicand, subtract it, or do nothing. The accumulator, the multiplier register and the guard bit then shift right by one as a single arithmetic unit. A run of identical multiplier bits costs no arithmetic, and negative operands need no sign fix-up at the end.

A caller waits for `ready_o`, then presents both operands with a one-cycle `start_i`. The block captures the operands and runs for exactly `WIDTH` step cycles. It then pulses `done_o`, and the product on `product_o` stays valid until the next accepted start. The accumulator carries one guard bit above the operand width. With that bit, subtracting the most negative multiplicand cannot wrap.

Top module: `booth_mult_seq`

## Requirements
- R1: After reset, `ready_o` is 1, `done_o` is 0 and `product_o` is 0.
- R2: A start is accepted on a clock edge where `ready_o` and `start_i` are both 1. `ready_o` is 0 during the `WIDTH` cycles that follow. `done_o` is 1 in the cycle after the `WIDTH`-th step edge, with `ready_o` also 1 in that cycle.
- R3: `done_o` is high for exactly one cycle per accepted start.
- R4: At `done_o`, `product_o` equals the signed product of the captured operands, read as a two's-complement value of `2*WIDTH` bits. For example, with `WIDTH`=5, 10111 (-9) times 10011 (-13) gives 00011_10101 (+117).
- R5: The most negative value times the most negative value gives the correct positive product. With `WIDTH`=5 that is -16 * -16 = 256, or 01_0000_0000.
- R6: `start_i` has no effect while `ready_o` is 0. The result and the completion timing stay those of the operation already running.
- R7: Operands are captured at the accepted start. Changes on `mcand_i` and `mplier_i` during a run do not change the result.
- R8: While idle with no start, `product_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| ready_o | output | 1 | Idle and able to accept a start |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | 2*WIDTH | Signed product, high half from the accumulator |

## Verification
A wrong add or subtract decision, or a shift that drops or duplicates the wrong bit, corrupts `product_o` for a large share of operand pairs. That error shows in the `done_o` cycle, at most `WIDTH` cycles after the start. A sweep over every operand pair at `WIDTH`=5 therefore hits each recoding pattern, both operand extremes, and the wrap case of the most negative multiplicand. A fault in the step counter shows up as `done_o` rising early or late, and that is measured in cycles from the accepted start.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_ADD, OP_SUB} booth_op_e;
  typedef enum logic {ST_IDLE, ST_RUN} booth_st_e;

  // pair = {multiplier lsb, guard bit}
  function automatic booth_op_e booth_decode(input logic lsb, input logic guard);
    case ({lsb, guard})
      2'b10:   return OP_SUB;
      2'b01:   return OP_ADD;
      default: return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o,
  output logic load_o,
  output logic step_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  booth_st_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last;

  assign ready_o = (st_q == ST_IDLE);
  assign load_o  = ready_o & start_i;
  assign step_o  = (st_q == ST_RUN);
  assign last    = step_o & (cnt_q == CNT_W'(1));
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load_o) begin
        st_q  <= ST_RUN;
        cnt_q <= CNT_W'(WIDTH);
      end else if (step_o) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last) st_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      lsb_i,
  input  logic      guard_i,
  output booth_op_e op_o
);
  assign op_o = booth_decode(lsb_i, guard_i);
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic [AW-1:0] acc_i,
  input  logic [AW-1:0] mc_i,
  input  booth_op_e     op_i,
  output logic [AW-1:0] res_o
);
  // carry-out beyond AW is dropped
  always_comb begin
    case (op_i)
      OP_ADD:  res_o = acc_i + mc_i;
      OP_SUB:  res_o = acc_i + ~mc_i + AW'(1);
      default: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/booth_mult_seq.sv
module booth_mult_seq
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               ready_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  // one guard bit so subtracting the most negative multiplicand cannot wrap
  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    acc_q, mc_q, sum;
  logic [WIDTH-1:0] mq_q;
  logic             guard_q;
  logic             load, step;
  booth_op_e        op;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .ready_o, .load_o(load), .step_o(step), .done_o
  );

  booth_recode u_rec (.lsb_i(mq_q[0]), .guard_i(guard_q), .op_o(op));

  booth_addsub #(.AW(AW)) u_as (.acc_i(acc_q), .mc_i(mc_q), .op_i(op), .res_o(sum));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mq_q    <= '0;
      guard_q <= 1'b0;
      mc_q    <= '0;
    end else if (load) begin
      acc_q   <= '0;
      mq_q    <= mplier_i;
      guard_q <= 1'b0;
      mc_q    <= {mcand_i[WIDTH-1], mcand_i};
    end else if (step) begin
      {acc_q, mq_q, guard_q} <= {sum[AW-1], sum, mq_q};
    end
  end

  assign product_o = {acc_q[WIDTH-1:0], mq_q};
endmodule

// File: rtl/booth_mult_seq_chk.sv
module booth_mult_seq_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [WIDTH-1:0]   mcand_i,
  input logic [WIDTH-1:0]   mplier_i,
  input logic               ready_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o
);
  localparam int CW = $clog2(WIDTH + 2) + 1;

  logic [WIDTH-1:0]   a_q, b_q;
  logic [CW-1:0]      run_q;
  logic signed [2*WIDTH-1:0] ea, eb, ep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      run_q <= '0;
    end else if (ready_o && start_i) begin
      a_q   <= mcand_i;
      b_q   <= mplier_i;
      run_q <= '0;
    end else if (!ready_o) begin
      run_q <= run_q + CW'(1);
    end
  end

  assign ea = {{WIDTH{a_q[WIDTH-1]}}, a_q};
  assign eb = {{WIDTH{b_q[WIDTH-1]}}, b_q};
  assign ep = ea * eb;

  a_r2_done_after_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> run_q == CW'(WIDTH));
  a_r2_ready_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
  a_r6_busy_only_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(start_i));
  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r4_product_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> product_o == ep);
  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> $stable(product_o));
endmodule

bind booth_mult_seq booth_mult_seq_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/booth_mult_seq_bench.sv
module booth_mult_seq_bench;
  localparam int W = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0, mplier = '0;
  logic           ready, done;
  logic [2*W-1:0] product;

  int  n_vec = 0, n_bad = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  booth_mult_seq #(.WIDTH(W)) u_booth_mult_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mcand_i(mcand), .mplier_i(mplier),
    .ready_o(ready), .done_o(done), .product_o(product)
  );

  function automatic logic [2*W-1:0] expect_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    longint pa = longint'($signed(a));
    longint pb = longint'($signed(b));
    longint pp = pa * pb;
    return pp[2*W-1:0];
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one operation; optionally poke start and operands while busy
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke, input string req);
    int cyc = 0;
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", 10'(ready), 10'(0));
    while (!done && cyc < 4 * W) begin
      if (poke) begin
        start = 1'b1; mcand = ~a; mplier = b ^ 5'b10101;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (poke) check("R6 R7 timing with busy pokes", 10'(cyc), 10'(W));
    else      check("R2 step count", 10'(cyc), 10'(W));
    check(req, product, expect_prod(a, b));
    check("R2 ready with done", 10'(ready), 10'(1));
    @(negedge clk);
    check("R3 done single cycle", 10'(done), 10'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset product", product, '0);
    check("R1 reset ready", 10'(ready), 10'(1));
    check("R1 reset done", 10'(done), 10'(0));
    rst_n = 1'b1;
    @(negedge clk);

    run(5'b10111, 5'b10011, 0, "R4 worked example");
    check("R4 example value", product, 10'b00011_10101);
    run(5'b10000, 5'b10000, 0, "R5 most negative squared");
    check("R5 value", product, 10'b01_0000_0000);

    run(5'b10111, 5'b10011, 1, "R6 R7 busy start and operand change ignored");

    held = product;
    mcand = 5'b01010; mplier = 5'b11001;
    repeat (4) @(negedge clk);
    check("R8 hold while idle", product, held);

    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run(W'(a), W'(b), 0, "R4 sweep");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule